// File: doc/BRIEF.md
# Receiver Mute-Mode Wakeup Controller

This block sits beside a UART receiver in a multiprocessor serial network and decides whether each received character reaches the host. Software can put the receiver to sleep by setting the mute flag (`rwu`). While muted, incoming characters are filtered out: `char_deliver` stays low, so the receiver never sets its data-ready flag and never raises a receive interrupt. The hardware clears the mute flag when it sees the selected wake condition.

Two wake methods are available, chosen by `wake_sel`. With `wake_sel` = 0, an idle line wakes the receiver. With `wake_sel` = 1, an address character wakes it. An address character has its MSB set and its low 4 bits equal to `node_addr`. The matching address character is delivered in the same cycle that it wakes the receiver. In idle-line mode the receiver cannot be muted until at least one character has been delivered since `rx_enable` rose. In address mode, software writes to the mute flag are locked out while the receiver's data-ready flag (`rxne`) is high.

The controller has four states:
- FRESH: enabled, unmuted, and no character delivered yet.
- FRESH_MUTED: muted before any character was delivered.
- ACTIVE: unmuted, with at least one character delivered.
- MUTED: muted, with at least one character delivered.

Its transitions are:
- FRESH→ACTIVE on a delivered character.
- FRESH→FRESH_MUTED or FRESH→MUTED on an accepted software set in address mode. The second applies when a character arrives in the same cycle.
- ACTIVE→MUTED on an accepted software set.
- MUTED→ACTIVE on a wake event or an accepted software clear.
- FRESH_MUTED→ACTIVE on a matching address character.
- FRESH_MUTED→FRESH on an idle event in idle mode or an accepted software clear.
- Any state→FRESH when `rx_enable` is low.

Top module: `mute_wake_ctrl`

## Requirements
- R1: After reset, `rwu` is 0.
- R2: While `rx_enable` is 0, `char_deliver` is 0, `rwu` is 0 one cycle later, and software writes have no effect.
- R3: In idle-line mode (`wake_sel`=0), a software write of 1 to the mute flag is ignored until a character has been delivered since enable.
- R4: In address mode (`wake_sel`=1) with `rxne`=0, a software write of 1 sets `rwu` on the next cycle, even before any character.
- R5: In address mode, software writes of 0 or 1 are ignored while `rxne`=1.
- R6: While `rwu`=1, a character is not delivered unless it is a matching address character in address mode. An idle event in address mode does not wake the receiver.
- R7: In address mode while muted, a character with MSB=1 and low 4 bits equal to `node_addr` is delivered in the same cycle, and `rwu` reads 0 on the next cycle.
- R8: A character with MSB=0 does not wake the receiver, even if its low 4 bits match.
- R9: In idle-line mode while muted, `idle_det`=1 clears `rwu` on the next cycle. A character in that same cycle is suppressed, and the next character is delivered.
- R10: In idle-line mode, after a character has been delivered, a software write of 1 sets `rwu` on the next cycle.
- R11: While muted, an accepted software write of 0 clears `rwu` on the next cycle.
- R12: While enabled and unmuted, every character is delivered in its own cycle.
- R13: Dropping `rx_enable` forgets earlier deliveries, so after re-enable the idle-line mode again needs a fresh character before it can be muted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_enable | input | 1 | Receiver enable |
| wake_sel | input | 1 | 0 = idle-line wake, 1 = address-character wake |
| node_addr | input | ADDR_W | This node's address |
| char_valid | input | 1 | One-cycle strobe for a received character |
| char_msb | input | 1 | MSB of the received character |
| char_tag | input | ADDR_W | Low bits of the received character |
| idle_det | input | 1 | One-cycle strobe: idle line detected |
| rwu_wr | input | 1 | Software write strobe to the mute flag |
| rwu_wr_val | input | 1 | Value written to the mute flag |
| rxne | input | 1 | Receiver data-ready flag |
| rwu | output | 1 | Mute flag (1 = muted) |
| char_deliver | output | 1 | Character passes on to set data-ready and interrupt |

## Verification
Each result has its own timing:
- `char_deliver` is combinational, so it is valid in the same cycle as the `char_valid` strobe.
- Every change to `rwu` becomes visible one rising edge after the stimulus that causes it.

The bench applies one stimulus per cycle, driving it just after the falling edge. One nanosecond later it compares both outputs against a behavioural model:
- `char_deliver` is checked against the model computed from the current inputs.
- `rwu` is checked against the model state from the previous edge.

The model is updated only after the rising edge, so each expected value is tied to the exact cycle in which it is due.

// File: rtl/mute_pkg.sv
package mute_pkg;

    typedef enum logic [1:0] {
        ST_FRESH       = 2'd0,
        ST_FRESH_MUTED = 2'd1,
        ST_ACTIVE      = 2'd2,
        ST_MUTED       = 2'd3
    } mute_state_t;

    function automatic logic is_muted(input mute_state_t s);
        return (s == ST_MUTED) || (s == ST_FRESH_MUTED);
    endfunction

endpackage

// File: rtl/mute_addr_match.sv
module mute_addr_match #(
    parameter int ADDR_W = 4
) (
    input  logic              char_msb,
    input  logic [ADDR_W-1:0] char_tag,
    input  logic [ADDR_W-1:0] node_addr,
    output logic              addr_hit
);
    logic [ADDR_W-1:0] bit_eq;

    genvar gi;
    generate
        for (gi = 0; gi < ADDR_W; gi++) begin : g_cmp
            assign bit_eq[gi] = ~(char_tag[gi] ^ node_addr[gi]);
        end
    endgenerate

    assign addr_hit = char_msb & (&bit_eq);
endmodule

// File: rtl/mute_sw_filter.sv
module mute_sw_filter (
    input  logic rwu_wr,
    input  logic rwu_wr_val,
    input  logic wake_sel,
    input  logic rxne,
    output logic req_set,
    output logic req_clr
);
    logic locked;

    always_comb begin
        locked  = wake_sel & rxne;
        req_set = rwu_wr &  rwu_wr_val & ~locked;
        req_clr = rwu_wr & ~rwu_wr_val & ~locked;
    end
endmodule

// File: rtl/mute_wake_fsm.sv
module mute_wake_fsm
    import mute_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic wake_sel,
    input  logic char_valid,
    input  logic addr_hit,
    input  logic idle_det,
    input  logic req_set,
    input  logic req_clr,
    output logic muted,
    output logic deliver
);
    mute_state_t state_q, state_d;
    logic        addr_wake;
    logic        idle_wake;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_FRESH;
        else        state_q <= state_d;
    end

    always_comb begin
        addr_wake = wake_sel & char_valid & addr_hit;
        idle_wake = ~wake_sel & idle_det;
        state_d   = state_q;
        if (!enable) begin
            state_d = ST_FRESH;
        end else begin
            unique case (state_q)
                ST_FRESH: begin
                    if (req_set && wake_sel)
                        state_d = char_valid ? ST_MUTED : ST_FRESH_MUTED;
                    else if (char_valid)
                        state_d = ST_ACTIVE;
                end
                ST_ACTIVE: begin
                    if (req_set) state_d = ST_MUTED;
                end
                ST_MUTED: begin
                    if (addr_wake || idle_wake || req_clr) state_d = ST_ACTIVE;
                end
                ST_FRESH_MUTED: begin
                    if (addr_wake)                   state_d = ST_ACTIVE;
                    else if (idle_wake || req_clr)   state_d = ST_FRESH;
                end
                default: state_d = ST_FRESH;
            endcase
        end
    end

    always_comb begin
        muted   = is_muted(state_q);
        deliver = enable & char_valid & (~muted | (wake_sel & addr_hit));
    end
endmodule

// File: rtl/mute_wake_ctrl.sv
module mute_wake_ctrl #(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_enable,
    input  logic              wake_sel,
    input  logic [ADDR_W-1:0] node_addr,
    input  logic              char_valid,
    input  logic              char_msb,
    input  logic [ADDR_W-1:0] char_tag,
    input  logic              idle_det,
    input  logic              rwu_wr,
    input  logic              rwu_wr_val,
    input  logic              rxne,
    output logic              rwu,
    output logic              char_deliver
);
    logic addr_hit;
    logic req_set;
    logic req_clr;

    mute_addr_match #(.ADDR_W(ADDR_W)) u_match (
        .char_msb (char_msb),
        .char_tag (char_tag),
        .node_addr(node_addr),
        .addr_hit (addr_hit)
    );

    mute_sw_filter u_filter (
        .rwu_wr    (rwu_wr),
        .rwu_wr_val(rwu_wr_val),
        .wake_sel  (wake_sel),
        .rxne      (rxne),
        .req_set   (req_set),
        .req_clr   (req_clr)
    );

    mute_wake_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (rx_enable),
        .wake_sel  (wake_sel),
        .char_valid(char_valid),
        .addr_hit  (addr_hit),
        .idle_det  (idle_det),
        .req_set   (req_set),
        .req_clr   (req_clr),
        .muted     (rwu),
        .deliver   (char_deliver)
    );
endmodule

// File: rtl/mute_wake_chk.sv
module mute_wake_chk #(
    parameter int ADDR_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rx_enable,
    input logic              wake_sel,
    input logic [ADDR_W-1:0] node_addr,
    input logic              char_valid,
    input logic              char_msb,
    input logic [ADDR_W-1:0] char_tag,
    input logic              idle_det,
    input logic              rwu_wr,
    input logic              rxne,
    input logic              rwu,
    input logic              char_deliver
);
    logic match_char;
    assign match_char = char_valid && char_msb && (char_tag == node_addr);

    a_r2_off_unmuted: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_enable |=> !rwu);
    a_r2_off_no_deliver: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_enable |-> !char_deliver);
    a_r5_write_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_enable && wake_sel && rxne && rwu_wr && !char_valid) |=> (rwu == $past(rwu)));
    a_r6_mute_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_enable && rwu && char_valid && !(wake_sel && match_char)) |-> !char_deliver);
    a_r7_match_delivers: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_enable && rwu && wake_sel && match_char) |-> char_deliver);
    a_r7_match_wakes: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_enable && rwu && wake_sel && match_char) |=> !rwu);
    a_r9_idle_wakes: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_enable && !wake_sel && rwu && idle_det) |=> !rwu);
    a_r12_active_delivers: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_enable && !rwu && char_valid) |-> char_deliver);
endmodule

bind mute_wake_ctrl mute_wake_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .rx_enable   (rx_enable),
    .wake_sel    (wake_sel),
    .node_addr   (node_addr),
    .char_valid  (char_valid),
    .char_msb    (char_msb),
    .char_tag    (char_tag),
    .idle_det    (idle_det),
    .rwu_wr      (rwu_wr),
    .rxne        (rxne),
    .rwu         (rwu),
    .char_deliver(char_deliver)
);

// File: tb/mute_wake_ctrl_tb.sv
`timescale 1ns/1ps
module mute_wake_ctrl_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_enable = 1'b0;
    logic       wake_sel = 1'b0;
    logic [3:0] node_addr = 4'hA;
    logic       char_valid = 1'b0;
    logic       char_msb = 1'b0;
    logic [3:0] char_tag = 4'h0;
    logic       idle_det = 1'b0;
    logic       rwu_wr = 1'b0;
    logic       rwu_wr_val = 1'b0;
    logic       rxne = 1'b0;
    logic       rwu;
    logic       char_deliver;

    int errs = 0;
    int checks = 0;
    bit done = 1'b0;
    int m_seen = 0;
    int m_rwu = 0;

    always #5 clk = ~clk;

    mute_wake_ctrl #(.ADDR_W(4)) u_dut (
        .clk(clk), .rst_n(rst_n), .rx_enable(rx_enable), .wake_sel(wake_sel),
        .node_addr(node_addr), .char_valid(char_valid), .char_msb(char_msb),
        .char_tag(char_tag), .idle_det(idle_det), .rwu_wr(rwu_wr),
        .rwu_wr_val(rwu_wr_val), .rxne(rxne), .rwu(rwu), .char_deliver(char_deliver)
    );

    task automatic check(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errs++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic step(input string tag, input bit en, input bit ws, input bit cv,
                        input logic [7:0] cd, input bit idl, input bit wr, input bit wv,
                        input bit rx);
        int exp_del;
        int hit;
        int hw_wake;
        int sw_ok;
        @(negedge clk);
        rx_enable = en; wake_sel = ws; char_valid = cv; char_msb = cd[7];
        char_tag = cd[3:0]; idle_det = idl; rwu_wr = wr; rwu_wr_val = wv; rxne = rx;
        #1;
        hit = (cd[7] && cd[3:0] == node_addr) ? 1 : 0;
        exp_del = (en && cv && (m_rwu == 0 || (ws && hit == 1))) ? 1 : 0;
        check(tag, "char_deliver", int'(char_deliver), exp_del);
        check(tag, "rwu", int'(rwu), m_rwu);
        @(posedge clk);
        if (!en) begin
            m_seen = 0; m_rwu = 0;
        end else begin
            hw_wake = (m_rwu == 1 && ((!ws && idl) || (ws && cv && hit == 1))) ? 1 : 0;
            sw_ok = (wr && !(ws && rx) && (ws || m_seen == 1 || !wv)) ? 1 : 0;
            if (hw_wake == 1) m_rwu = 0;
            else if (sw_ok == 1) m_rwu = wv ? 1 : 0;
            if (exp_del == 1) m_seen = 1;
        end
    endtask

    task automatic summary();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            errs++; checks++;
            $display("FAIL watchdog expired");
            summary();
        end
    end

    initial begin
        #12;
        check("R1", "rwu in reset", int'(rwu), 0);
        @(negedge clk); rst_n = 1'b1;
        // R2: disabled receiver delivers nothing and ignores writes
        step("R2", 0, 1, 1, 8'h8A, 0, 1, 1, 0);
        step("R2", 0, 0, 1, 8'h11, 0, 1, 1, 0);
        // R3: idle mode, fresh enable, set write ignored
        step("R3", 1, 0, 0, 8'h00, 0, 1, 1, 0);
        step("R3", 1, 0, 0, 8'h00, 0, 0, 0, 0);
        // R12: active delivery
        step("R12", 1, 0, 1, 8'h11, 0, 0, 0, 1);
        step("R12", 1, 0, 1, 8'h8A, 0, 0, 0, 1);
        // R10: now mute accepted
        step("R10", 1, 0, 0, 8'h00, 0, 1, 1, 0);
        step("R10", 1, 0, 0, 8'h00, 0, 0, 0, 0);
        // R6: muted chars suppressed, address char irrelevant in idle mode
        step("R6", 1, 0, 1, 8'h22, 0, 0, 0, 0);
        step("R6", 1, 0, 1, 8'h8A, 0, 0, 0, 0);
        // R9: idle wakes; char same cycle suppressed; next delivered
        step("R9", 1, 0, 1, 8'h33, 1, 0, 0, 0);
        step("R9", 1, 0, 1, 8'h44, 0, 0, 0, 0);
        // R11: software clear
        step("R11", 1, 0, 0, 8'h00, 0, 1, 1, 0);
        step("R11", 1, 0, 0, 8'h00, 0, 1, 0, 0);
        step("R11", 1, 0, 1, 8'h55, 0, 0, 0, 0);
        // R5: address mode lock while rxne
        step("R5", 1, 1, 0, 8'h00, 0, 1, 1, 1);
        step("R5", 1, 1, 0, 8'h00, 0, 0, 0, 1);
        // R4: address mode set
        step("R4", 1, 1, 0, 8'h00, 0, 1, 1, 0);
        step("R5", 1, 1, 0, 8'h00, 0, 1, 0, 1);
        step("R5", 1, 1, 0, 8'h00, 0, 0, 0, 1);
        // R8: MSB clear with matching low bits
        step("R8", 1, 1, 1, 8'h0A, 0, 0, 0, 0);
        // R6: wrong address, idle in address mode
        step("R6", 1, 1, 1, 8'h8B, 0, 0, 0, 0);
        step("R6", 1, 1, 0, 8'h00, 1, 0, 0, 0);
        // R7: matching address wakes and is delivered
        step("R7", 1, 1, 1, 8'hFA, 0, 0, 0, 0);
        step("R7", 1, 1, 1, 8'h12, 0, 0, 0, 0);
        // R7 with another node address
        node_addr = 4'h3;
        step("R4", 1, 1, 0, 8'h00, 0, 1, 1, 0);
        step("R7", 1, 1, 1, 8'h8A, 0, 0, 0, 0);
        step("R7", 1, 1, 1, 8'h83, 0, 0, 0, 0);
        // R13: enable drop forgets history
        step("R13", 1, 0, 0, 8'h00, 0, 1, 1, 0);
        step("R13", 0, 0, 0, 8'h00, 0, 0, 0, 0);
        step("R13", 1, 0, 0, 8'h00, 0, 1, 1, 0);
        step("R13", 1, 0, 1, 8'h21, 0, 0, 0, 0);
        step("R13", 1, 0, 0, 8'h00, 0, 1, 1, 0);
        step("R13", 0, 0, 0, 8'h00, 0, 0, 0, 0);
        // R4: address-mode mute before any char, then clear, idle mode still unprimed
        step("R4", 1, 1, 0, 8'h00, 0, 1, 1, 0);
        step("R11", 1, 1, 0, 8'h00, 0, 1, 0, 0);
        step("R3", 1, 0, 0, 8'h00, 0, 1, 1, 0);
        step("R3", 1, 0, 0, 8'h00, 0, 0, 0, 0);
        // R4: set plus char same cycle, then idle-mode wake from mute
        step("R4", 1, 1, 1, 8'h31, 0, 1, 1, 0);
        step("R9", 1, 0, 0, 8'h00, 1, 0, 0, 0);
        step("R12", 1, 0, 1, 8'h66, 0, 0, 0, 0);
        summary();
    end
endmodule